// File: doc/BRIEF.md
# Pipeline Commit and Exception Gating Control

This block is the per-cycle commit controller of a five-stage in-order processor pipeline. Each cycle it looks at the exception codes of the instructions sitting in the write-back, memory and execute slots. From those codes it decides whether program-visible memory and the condition codes may be updated in this cycle. The decision depends on two things: whether any instruction further down the pipe has faulted, and whether the number of real (non-bubble) instructions ahead of the memory and execute stages has already used up an instruction budget supplied by the surrounding logic.

When the instruction in the execute slot carries a real exception, the block asks for the fetch/decode and decode/execute pipeline registers to be turned into bubbles on the following cycle. This stops younger instructions from moving on behind the faulting one. The block also keeps two performance counters: completed instructions and elapsed cycles. The cycle counter holds still while the pipe is still filling after reset.

Top module: `pipe_commit_ctrl`

## Requirements
- R1: Exception codes are 3 bits: NONE=0, BUBBLE=1, ADDR=2, INSTR=3, HALT=4, PIPE=5. A slot counts as clean when its code is NONE or BUBBLE. `mem_update_en` is low in any cycle where the write-back slot is not clean.
- R2: The number of instructions ahead of memory is 1 when the write-back code is not BUBBLE and 0 otherwise. The number ahead of execute is that value plus 1 when the memory code is not BUBBLE.
- R3: `mem_update_en` is high, in the same cycle, exactly when the write-back slot is clean and the count ahead of memory is below `instr_budget` (unsigned). `cc_update_en` is high exactly when `mem_update_en` is high, the memory slot is clean, and the count ahead of execute is below `instr_budget`.
- R4: With `instr_budget` equal to 0, both update enables are low whatever the slot codes are.
- R5: When the execute-slot code is neither NONE nor BUBBLE at a clock edge, `fd_bubble` and `de_bubble` are both high for the cycle after that edge. In every other case they are low after the edge.
- R6: At a clock edge where the write-back code is not BUBBLE and `wb_opcode` differs from the second-half-of-pop code (default 15), `instr_count` increments by one. An opcode of 15 or a BUBBLE code leaves it unchanged.
- R7: The completion event of R6 also increments `cycle_count` and clears the start-up flag.
- R8: At an edge without a completion event, `cycle_count` increments only if the start-up flag has already been cleared. Before the first completion, bubbles and opcode-15 slots leave it at 0.
- R9: Synchronous active-high reset sets both counters to 0, drives both bubble requests low and sets the start-up flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_exc | input | 3 | Exception code of the write-back slot |
| mem_exc | input | 3 | Exception code of the memory slot |
| ex_exc | input | 3 | Exception code of the execute slot |
| wb_opcode | input | 4 | Opcode of the write-back slot |
| instr_budget | input | 32 | Maximum instructions allowed to commit |
| mem_update_en | output | 1 | Memory write may happen this cycle |
| cc_update_en | output | 1 | Condition codes may update this cycle |
| fd_bubble | output | 1 | Force fetch/decode register to bubble |
| de_bubble | output | 1 | Force decode/execute register to bubble |
| instr_count | output | 32 | Completed-instruction counter |
| cycle_count | output | 32 | Elapsed-cycle counter |

## Verification
The two update enables are combinational, so each table vector is applied just after a falling edge and the enables are sampled a short time later, before the next rising edge. The bubble requests and both counters are registered and change one rising edge after the stimulus that causes them. The bench therefore sets the stimulus at a falling edge, lets exactly one rising edge pass, and samples at the next falling edge. Counter sequences are checked after every single edge, so a missed or extra increment shows up at the cycle where it happens.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    localparam int EXC_W = 3;

    typedef enum logic [EXC_W-1:0] {
        EXC_NONE   = 3'd0,
        EXC_BUBBLE = 3'd1,
        EXC_ADDR   = 3'd2,
        EXC_INSTR  = 3'd3,
        EXC_HALT   = 3'd4,
        EXC_PIPE   = 3'd5
    } exc_e;

    typedef struct packed {
        logic [1:0] ahead_mem;
        logic [1:0] ahead_ex;
        logic       wb_clean;
        logic       mem_clean;
    } slot_view_t;

    // clean: no fault pending in the slot
    function automatic logic slot_clean(input logic [EXC_W-1:0] code);
        return (code == EXC_NONE) || (code == EXC_BUBBLE);
    endfunction

    // real: the slot holds an instruction, not a bubble
    function automatic logic slot_real(input logic [EXC_W-1:0] code);
        return code != EXC_BUBBLE;
    endfunction

    function automatic slot_view_t view_slots(input logic [EXC_W-1:0] wb,
                                              input logic [EXC_W-1:0] mem);
        slot_view_t v;
        v.ahead_mem = {1'b0, slot_real(wb)};
        v.ahead_ex  = v.ahead_mem + {1'b0, slot_real(mem)};
        v.wb_clean  = slot_clean(wb);
        v.mem_clean = slot_clean(mem);
        return v;
    endfunction

endpackage

// File: rtl/pcc_gate.sv
module pcc_gate
    import pcc_pkg::*;
#(
    parameter int BUD_W = 32
) (
    input  logic [EXC_W-1:0] wb_exc,
    input  logic [EXC_W-1:0] mem_exc,
    input  logic [BUD_W-1:0] budget,
    output logic             mem_en,
    output logic             cc_en
);
    slot_view_t       v;
    logic [BUD_W-1:0] ahead_mem_w;
    logic [BUD_W-1:0] ahead_ex_w;
    logic             mem_room;
    logic             ex_room;

    always_comb begin
        v           = view_slots(wb_exc, mem_exc);
        ahead_mem_w = BUD_W'(v.ahead_mem);
        ahead_ex_w  = BUD_W'(v.ahead_ex);
        mem_room    = ahead_mem_w < budget;
        ex_room     = ahead_ex_w < budget;
        mem_en      = v.wb_clean && mem_room;
        cc_en       = mem_en && v.mem_clean && ex_room;
    end
endmodule

// File: rtl/pcc_squash.sv
module pcc_squash
    import pcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EXC_W-1:0] ex_exc,
    output logic             fd_bubble,
    output logic             de_bubble
);
    logic fault_in_ex;

    assign fault_in_ex = !slot_clean(ex_exc);

    always_ff @(posedge clk) begin
        if (rst) begin
            fd_bubble <= 1'b0;
            de_bubble <= 1'b0;
        end else begin
            fd_bubble <= fault_in_ex;
            de_bubble <= fault_in_ex;
        end
    end
endmodule

// File: rtl/pcc_counter.sv
module pcc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (inc)
            q <= q + CNT_W'(1);
    end
endmodule

// File: rtl/pcc_perf.sv
module pcc_perf
    import pcc_pkg::*;
#(
    parameter int          CNT_W     = 32,
    parameter int          OP_W      = 4,
    parameter logic [OP_W-1:0] POP2_CODE = 4'd15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EXC_W-1:0] wb_exc,
    input  logic [OP_W-1:0]  wb_opcode,
    output logic [CNT_W-1:0] instr_count,
    output logic [CNT_W-1:0] cycle_count
);
    localparam int N_CNT = 2;

    logic             starting;
    logic             completes;
    logic [N_CNT-1:0] inc;
    logic [CNT_W-1:0] cnt [N_CNT];

    assign completes = slot_real(wb_exc) && (wb_opcode != POP2_CODE);
    assign inc[0]    = completes;
    assign inc[1]    = completes || !starting;

    always_ff @(posedge clk) begin
        if (rst)
            starting <= 1'b1;
        else if (completes)
            starting <= 1'b0;
    end

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        pcc_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .inc (inc[i]),
            .q   (cnt[i])
        );
    end

    assign instr_count = cnt[0];
    assign cycle_count = cnt[1];
endmodule

// File: rtl/pipe_commit_ctrl.sv
module pipe_commit_ctrl
    import pcc_pkg::*;
#(
    parameter int              BUD_W     = 32,
    parameter int              CNT_W     = 32,
    parameter int              OP_W      = 4,
    parameter logic [OP_W-1:0] POP2_CODE = 4'd15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       wb_exc,
    input  logic [2:0]       mem_exc,
    input  logic [2:0]       ex_exc,
    input  logic [OP_W-1:0]  wb_opcode,
    input  logic [BUD_W-1:0] instr_budget,
    output logic             mem_update_en,
    output logic             cc_update_en,
    output logic             fd_bubble,
    output logic             de_bubble,
    output logic [CNT_W-1:0] instr_count,
    output logic [CNT_W-1:0] cycle_count
);
    pcc_gate #(.BUD_W(BUD_W)) u_gate (
        .wb_exc  (wb_exc),
        .mem_exc (mem_exc),
        .budget  (instr_budget),
        .mem_en  (mem_update_en),
        .cc_en   (cc_update_en)
    );

    pcc_squash u_squash (
        .clk       (clk),
        .rst       (rst),
        .ex_exc    (ex_exc),
        .fd_bubble (fd_bubble),
        .de_bubble (de_bubble)
    );

    pcc_perf #(
        .CNT_W     (CNT_W),
        .OP_W      (OP_W),
        .POP2_CODE (POP2_CODE)
    ) u_perf (
        .clk         (clk),
        .rst         (rst),
        .wb_exc      (wb_exc),
        .wb_opcode   (wb_opcode),
        .instr_count (instr_count),
        .cycle_count (cycle_count)
    );
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
    parameter int              BUD_W     = 32,
    parameter int              CNT_W     = 32,
    parameter int              OP_W      = 4,
    parameter logic [OP_W-1:0] POP2_CODE = 4'd15
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       wb_exc,
    input logic [2:0]       mem_exc,
    input logic [2:0]       ex_exc,
    input logic [OP_W-1:0]  wb_opcode,
    input logic [BUD_W-1:0] instr_budget,
    input logic             mem_update_en,
    input logic             cc_update_en,
    input logic             fd_bubble,
    input logic             de_bubble,
    input logic [CNT_W-1:0] instr_count,
    input logic [CNT_W-1:0] cycle_count
);
    localparam logic [2:0] C_NONE   = 3'd0;
    localparam logic [2:0] C_BUBBLE = 3'd1;

    assert_dirty_wb_blocks_R1: assert property (@(posedge clk) disable iff (rst)
        (wb_exc != C_NONE && wb_exc != C_BUBBLE) |-> !mem_update_en);

    assert_cc_needs_mem_R3: assert property (@(posedge clk) disable iff (rst)
        cc_update_en |-> mem_update_en);

    assert_zero_budget_R4: assert property (@(posedge clk) disable iff (rst)
        (instr_budget == '0) |-> (!mem_update_en && !cc_update_en));

    assert_fault_squashes_R5: assert property (@(posedge clk) disable iff (rst)
        (ex_exc != C_NONE && ex_exc != C_BUBBLE) |=> (fd_bubble && de_bubble));

    assert_clean_no_squash_R5: assert property (@(posedge clk) disable iff (rst)
        (ex_exc == C_NONE || ex_exc == C_BUBBLE) |=> (!fd_bubble && !de_bubble));

    assert_instr_step_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (instr_count == $past(instr_count) ||
                  instr_count == $past(instr_count) + CNT_W'(1)));

    assert_completion_ticks_R7: assert property (@(posedge clk) disable iff (rst)
        (wb_exc != C_BUBBLE && wb_opcode != POP2_CODE)
        |=> (cycle_count == $past(cycle_count) + CNT_W'(1)));

    assert_cycle_step_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cycle_count == $past(cycle_count) ||
                  cycle_count == $past(cycle_count) + CNT_W'(1)));

    assert_reset_state_R9: assert property (@(posedge clk)
        rst |=> (instr_count == '0 && cycle_count == '0 && !fd_bubble && !de_bubble));
endmodule

bind pipe_commit_ctrl pcc_checker #(
    .BUD_W     (BUD_W),
    .CNT_W     (CNT_W),
    .OP_W      (OP_W),
    .POP2_CODE (POP2_CODE)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wb_exc        (wb_exc),
    .mem_exc       (mem_exc),
    .ex_exc        (ex_exc),
    .wb_opcode     (wb_opcode),
    .instr_budget  (instr_budget),
    .mem_update_en (mem_update_en),
    .cc_update_en  (cc_update_en),
    .fd_bubble     (fd_bubble),
    .de_bubble     (de_bubble),
    .instr_count   (instr_count),
    .cycle_count   (cycle_count)
);

// File: tb/sim_pipe_commit_ctrl.sv
module sim_pipe_commit_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  wb_exc = 3'd1;
    logic [2:0]  mem_exc = 3'd1;
    logic [2:0]  ex_exc = 3'd1;
    logic [3:0]  wb_opcode = 4'd0;
    logic [31:0] instr_budget = 32'd4;
    logic        mem_update_en, cc_update_en, fd_bubble, de_bubble;
    logic [31:0] instr_count, cycle_count;

    int n_checks = 0;
    int n_errors = 0;
    int wd_cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pipe_commit_ctrl u0 (
        .clk           (clk),
        .rst           (rst),
        .wb_exc        (wb_exc),
        .mem_exc       (mem_exc),
        .ex_exc        (ex_exc),
        .wb_opcode     (wb_opcode),
        .instr_budget  (instr_budget),
        .mem_update_en (mem_update_en),
        .cc_update_en  (cc_update_en),
        .fd_bubble     (fd_bubble),
        .de_bubble     (de_bubble),
        .instr_count   (instr_count),
        .cycle_count   (cycle_count)
    );

    // codes: NONE=0 BUBBLE=1 ADDR=2 INSTR=3 HALT=4 PIPE=5
    // vector: {wb[39:37], mem[36:34], budget[33:2], exp_mem[1], exp_cc[0]}
    localparam int NV = 14;
    localparam logic [39:0] VEC [NV] = '{
        {3'd0, 3'd0, 32'd2,          1'b1, 1'b0},
        {3'd0, 3'd0, 32'd3,          1'b1, 1'b1},
        {3'd1, 3'd0, 32'd1,          1'b1, 1'b0},
        {3'd1, 3'd1, 32'd1,          1'b1, 1'b1},
        {3'd1, 3'd1, 32'd0,          1'b0, 1'b0},
        {3'd2, 3'd0, 32'd5,          1'b0, 1'b0},
        {3'd0, 3'd3, 32'd5,          1'b1, 1'b0},
        {3'd0, 3'd1, 32'd2,          1'b1, 1'b1},
        {3'd0, 3'd1, 32'd1,          1'b0, 1'b0},
        {3'd4, 3'd1, 32'd9,          1'b0, 1'b0},
        {3'd1, 3'd5, 32'd9,          1'b1, 1'b0},
        {3'd1, 3'd4, 32'd1,          1'b1, 1'b0},
        {3'd1, 3'd0, 32'd2,          1'b1, 1'b1},
        {3'd0, 3'd0, 32'hFFFF_FFFF,  1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one rising edge, then sample at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        wd_cycles++;
        if (wd_cycles > 5000 && !done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd_cycles, 5000);
            finish_run();
        end
    end

    initial begin
        step();
        step();
        // R9 reset state
        check("R9 instr_count in reset", instr_count, 32'd0);
        check("R9 cycle_count in reset", cycle_count, 32'd0);
        check("R9 fd_bubble in reset", {31'd0, fd_bubble}, 32'd0);
        check("R9 de_bubble in reset", {31'd0, de_bubble}, 32'd0);
        rst = 1'b0;

        // R1 R2 R3 R4: combinational enables, one vector per falling edge
        for (int i = 0; i < NV; i++) begin
            wb_exc       = VEC[i][39:37];
            mem_exc      = VEC[i][36:34];
            instr_budget = VEC[i][33:2];
            #1;
            check($sformatf("R3 mem_update_en vector %0d", i), {31'd0, mem_update_en}, {31'd0, VEC[i][1]});
            check($sformatf("R3 cc_update_en vector %0d", i), {31'd0, cc_update_en}, {31'd0, VEC[i][0]});
            @(negedge clk);
        end

        // R4 zero budget with all slots clean
        wb_exc = 3'd0; mem_exc = 3'd0; instr_budget = 32'd0;
        #1;
        check("R4 zero budget mem", {31'd0, mem_update_en}, 32'd0);
        check("R4 zero budget cc", {31'd0, cc_update_en}, 32'd0);
        // R1 faulted write-back with large budget
        wb_exc = 3'd5; instr_budget = 32'd100;
        #1;
        check("R1 PIPE in write-back blocks mem", {31'd0, mem_update_en}, 32'd0);
        // R2 real write-back and memory exactly fill a budget of 2
        wb_exc = 3'd4; mem_exc = 3'd4; instr_budget = 32'd2;
        #1;
        check("R2 two ahead of execute, cc", {31'd0, cc_update_en}, 32'd0);

        // restart for counter checks
        @(negedge clk);
        rst = 1'b1; wb_exc = 3'd1; mem_exc = 3'd1; ex_exc = 3'd1; wb_opcode = 4'd0;
        step();
        rst = 1'b0;
        check("R9 counters cleared", cycle_count, 32'd0);

        // R8 start-up: bubbles do not count
        step(); step(); step();
        check("R8 cycle held during start-up", cycle_count, 32'd0);
        // R6 second-half-of-pop code does not complete
        wb_exc = 3'd0; wb_opcode = 4'd15;
        step();
        check("R6 pop2 no instr during start-up", instr_count, 32'd0);
        check("R8 pop2 no cycle during start-up", cycle_count, 32'd0);
        // R7 first completion
        wb_opcode = 4'd3;
        step();
        check("R6 first completion instr", instr_count, 32'd1);
        check("R7 first completion cycle", cycle_count, 32'd1);
        // R8 bubbles now count cycles
        wb_exc = 3'd1;
        step();
        check("R8 bubble cycle 2", cycle_count, 32'd2);
        step();
        check("R8 bubble cycle 3", cycle_count, 32'd3);
        check("R6 bubble no instr", instr_count, 32'd1);
        // R6 pop2 after start-up: cycle yes, instr no
        wb_exc = 3'd0; wb_opcode = 4'd15;
        step();
        check("R6 pop2 instr held", instr_count, 32'd1);
        check("R8 pop2 cycle counts", cycle_count, 32'd4);
        // R6 faulted but real instruction completes
        wb_exc = 3'd4; wb_opcode = 4'd0;
        step();
        check("R6 halt slot instr", instr_count, 32'd2);
        check("R7 halt slot cycle", cycle_count, 32'd5);
        wb_exc = 3'd1;

        // R5 squash requests
        ex_exc = 3'd2;
        #1;
        check("R5 no bubble before edge", {31'd0, fd_bubble}, 32'd0);
        step();
        check("R5 fd_bubble after ADDR", {31'd0, fd_bubble}, 32'd1);
        check("R5 de_bubble after ADDR", {31'd0, de_bubble}, 32'd1);
        ex_exc = 3'd0;
        step();
        check("R5 fd_bubble drops after NONE", {31'd0, fd_bubble}, 32'd0);
        check("R5 de_bubble drops after NONE", {31'd0, de_bubble}, 32'd0);
        ex_exc = 3'd5;
        step();
        check("R5 de_bubble after PIPE", {31'd0, de_bubble}, 32'd1);
        ex_exc = 3'd1;
        step();
        check("R5 no bubble after BUBBLE", {31'd0, fd_bubble}, 32'd0);
        ex_exc = 3'd3;
        step();
        check("R5 fd_bubble after INSTR", {31'd0, fd_bubble}, 32'd1);
        ex_exc = 3'd0;
        step();

        // R9 reset mid-run clears counters and bubbles
        ex_exc = 3'd4;
        step();
        rst = 1'b1;
        ex_exc = 3'd0;
        step();
        check("R9 instr after reset", instr_count, 32'd0);
        check("R9 cycle after reset", cycle_count, 32'd0);
        check("R9 bubble after reset", {31'd0, fd_bubble}, 32'd0);
        rst = 1'b0;
        step();
        check("R9 start-up flag set again", cycle_count, 32'd0);

        finish_run();
    end
endmodule